// File: doc/BRIEF.md
# Self-Test Observation Register

This block is an N-bit register that takes the place of an ordinary pipeline register and can also take part in self-test. The same flip-flops can load parallel data, clear, shift as a serial scan chain, or compact a stream of parallel words into a signature with a linear feedback shift register. When the parallel data is masked to zero in signature operation, the register runs as a pseudo-random pattern generator. This lets one register drive stimulus into a downstream logic cone in one test session and capture that cone's responses in another.

A small decoder turns a three-bit session code into the two internal mode bits. It also chooses what enters the first cell: the scan input or the feedback bit. The feedback taps are a parameter. The default of four cells with taps on the last two cells gives the primitive polynomial 1 + x^3 + x^4.

Top module: `stobs_register`

## Requirements
- R1: With `rst` high, the next rising clock edge clears every bit of `q`. This holds whatever `clk_en` and `sess_code` are.
- R2: Session code 3'b001 (clear) sets `q` to all zeros on the next enabled edge.
- R3: Session code 3'b000 (load) copies `par_d` into `q` on the next enabled edge.
- R4: Session code 3'b010 (scan) shifts `q` one place toward the most significant bit, with `scan_in` entering bit 0. `scan_out` always equals `q[N-1]`, in every session.
- R5: Session code 3'b100 (signature) sets q[i] to par_d[i] XOR q[i-1] for i >= 1, and q[0] to par_d[0] XOR fb. Here fb is the XOR of the bits of `q` selected by `TAPS`. The default is N=4 and TAPS=4'b1100, so fb = q[2] XOR q[3].
- R6: Session code 3'b011 (pattern generation) behaves as R5 with `par_d` ignored and treated as zero. From a nonzero seed, `q` never becomes zero and visits all 2^N-1 nonzero states before it returns to the seed. The all-zero state maps to itself.
- R7: Session codes 3'b101, 3'b110 and 3'b111 are reserved and leave `q` unchanged.
- R8: While `clk_en` is low and `rst` is low, no bit of `q` changes.
- R9: A new session code takes effect at the first edge at which it is presented. Changing the code on every cycle gives each edge the behaviour of the code present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Update enable; when low, all cells hold |
| sess_code | input | 3 | Session code: load, clear, scan, pattern generation, signature, or reserved |
| par_d | input | N | Parallel data from the upstream logic |
| scan_in | input | 1 | Serial input into the first cell during scan |
| q | output | N | Register contents |
| scan_out | output | 1 | Serial output, the last cell |

## Verification
The bench builds the block with its defaults, N=4 and TAPS=4'b1100. At that width the full pattern-generator cycle of 15 states can be walked exhaustively, and the bench confirms that every nonzero state appears exactly once before the seed returns. A reference model in the bench predicts each cycle under every session code. The stimulus switches codes every cycle, and it also covers enable-low and reset-override corners, with random parallel data that pattern generation must ignore.

// File: rtl/stobs_pkg.sv
package stobs_pkg;

  // Internal two-bit cell mode; the encoding is shared by every cell
  typedef enum logic [1:0] {
    MODE_SCAN  = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SIGN  = 2'b10,
    MODE_LOAD  = 2'b11
  } cell_mode_e;

  // Source of the first cell's serial input
  typedef enum logic {
    SRC_SCAN     = 1'b0,
    SRC_FEEDBACK = 1'b1
  } first_src_e;

  // Session codes seen at the block's edge
  localparam logic [2:0] SESS_LOAD  = 3'b000;
  localparam logic [2:0] SESS_CLEAR = 3'b001;
  localparam logic [2:0] SESS_SCAN  = 3'b010;
  localparam logic [2:0] SESS_PRPG  = 3'b011;
  localparam logic [2:0] SESS_SIGN  = 3'b100;

  typedef struct packed {
    cell_mode_e mode;
    first_src_e src;
    logic       upd;
    logic       zero_data;
  } sess_ctrl_t;

  // Next value of one cell given its mode, data bit and serial input
  function automatic logic cell_next(cell_mode_e m, logic d, logic ser);
    logic r;
    case (m)
      MODE_LOAD:  r = d;
      MODE_CLEAR: r = 1'b0;
      MODE_SCAN:  r = ser;
      MODE_SIGN:  r = d ^ ser;
      default:    r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/stobs_session_dec.sv
module stobs_session_dec
  import stobs_pkg::*;
(
  input  logic [2:0]  code,
  output sess_ctrl_t  ctrl
);

  always_comb begin
    ctrl.mode      = MODE_LOAD;
    ctrl.src       = SRC_SCAN;
    ctrl.upd       = 1'b1;
    ctrl.zero_data = 1'b0;
    case (code)
      SESS_LOAD:  ctrl.mode = MODE_LOAD;
      SESS_CLEAR: ctrl.mode = MODE_CLEAR;
      SESS_SCAN: begin
        ctrl.mode = MODE_SCAN;
        ctrl.src  = SRC_SCAN;
      end
      SESS_PRPG: begin
        ctrl.mode      = MODE_SIGN;
        ctrl.src       = SRC_FEEDBACK;
        ctrl.zero_data = 1'b1;
      end
      SESS_SIGN: begin
        ctrl.mode = MODE_SIGN;
        ctrl.src  = SRC_FEEDBACK;
      end
      default:    ctrl.upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/stobs_feedback.sv
module stobs_feedback #(
  parameter int              N    = 4,
  parameter logic [N-1:0]    TAPS = 4'b1100
) (
  input  logic [N-1:0] state,
  output logic         fb
);

  // XOR reduction built as a chain over the tapped cells
  logic [N:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign chain[i+1] = chain[i] ^ state[i];
    end else begin : g_off
      assign chain[i+1] = chain[i];
    end
  end

  assign fb = chain[N];

endmodule

// File: rtl/stobs_cell_array.sv
module stobs_cell_array
  import stobs_pkg::*;
#(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        upd,
  input  cell_mode_e  mode,
  input  logic        first_in,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] ser;
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign ser[i] = first_in;
    end else begin : g_body
      assign ser[i] = q[i-1];
    end
    assign nxt[i] = cell_next(mode, d[i], ser[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd) begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/stobs_register.sv
module stobs_register
  import stobs_pkg::*;
#(
  parameter int           N    = 4,
  parameter logic [N-1:0] TAPS = 4'b1100
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_en,
  input  logic [2:0]   sess_code,
  input  logic [N-1:0] par_d,
  input  logic         scan_in,
  output logic [N-1:0] q,
  output logic         scan_out
);

  localparam int LAST = N - 1;

  sess_ctrl_t   ctrl;
  logic         fb;
  logic         first_in;
  logic [N-1:0] d_eff;
  logic         upd;

  stobs_session_dec u_dec (
    .code (sess_code),
    .ctrl (ctrl)
  );

  stobs_feedback #(.N(N), .TAPS(TAPS)) u_fb (
    .state (q),
    .fb    (fb)
  );

  assign d_eff    = ctrl.zero_data ? '0 : par_d;
  assign first_in = (ctrl.src == SRC_FEEDBACK) ? fb : scan_in;
  assign upd      = clk_en & ctrl.upd;

  stobs_cell_array #(.N(N)) u_cells (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd),
    .mode     (ctrl.mode),
    .first_in (first_in),
    .d        (d_eff),
    .q        (q)
  );

  assign scan_out = q[LAST];

endmodule

// File: rtl/stobs_register_chk.sv
module stobs_register_chk #(
  parameter int           N    = 4,
  parameter logic [N-1:0] TAPS = 4'b1100
) (
  input logic         clk,
  input logic         rst,
  input logic         clk_en,
  input logic [2:0]   sess_code,
  input logic [N-1:0] par_d,
  input logic         scan_in,
  input logic [N-1:0] q,
  input logic         scan_out
);

  logic live;
  assign live = !rst && clk_en;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (live && sess_code == 3'b001) |=> (q == '0)); // R2

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    (live && sess_code == 3'b000) |=> (q == $past(par_d))); // R3

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (live && sess_code == 3'b010) |=>
      (q == {$past(q[N-2:0]), $past(scan_in)} && scan_out == $past(q[N-2]))); // R4

  AST_SIGN_COMPACT: assert property (@(posedge clk) disable iff (rst)
    (live && sess_code == 3'b100) |=>
      (q == ($past(par_d) ^ {$past(q[N-2:0]), ^($past(q) & TAPS)}))); // R5

  AST_PRPG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (live && sess_code == 3'b011 && q != '0) |=> (q != '0)); // R6

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sess_code[2] && sess_code[1:0] != 2'b00) |=> $stable(q)); // R7

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clk_en) |=> $stable(q)); // R8

endmodule

bind stobs_register stobs_register_chk #(.N(N), .TAPS(TAPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en    (clk_en),
  .sess_code (sess_code),
  .par_d     (par_d),
  .scan_in   (scan_in),
  .q         (q),
  .scan_out  (scan_out)
);

// File: tb/stobs_register_bench.sv
module stobs_register_bench;

  localparam int           N    = 4;
  localparam logic [N-1:0] TAPS = 4'b1100;
  localparam time          HALF = 4;   // 8 ns period, 125 MHz

  localparam logic [2:0] C_LOAD  = 3'b000;
  localparam logic [2:0] C_CLEAR = 3'b001;
  localparam logic [2:0] C_SCAN  = 3'b010;
  localparam logic [2:0] C_PRPG  = 3'b011;
  localparam logic [2:0] C_SIGN  = 3'b100;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clk_en = 1'b0;
  logic [2:0]   sess_code = 3'b000;
  logic [N-1:0] par_d = '0;
  logic         scan_in = 1'b0;
  logic [N-1:0] q;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0] q;
    string        tag;
  } exp_t;

  exp_t         exp_q[$];
  logic [N-1:0] mdl = '0;

  always #HALF clk = ~clk;

  stobs_register #(.N(N), .TAPS(TAPS)) u_stobs_register (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .sess_code (sess_code),
    .par_d     (par_d),
    .scan_in   (scan_in),
    .q         (q),
    .scan_out  (scan_out)
  );

  // Reference model written from the requirements
  function automatic logic [N-1:0] model_next(logic [N-1:0] m, logic r, logic en,
                                              logic [2:0] code, logic [N-1:0] d, logic si);
    logic fb;
    fb = ^(m & TAPS);
    if (r) return '0;
    if (!en) return m;
    case (code)
      C_LOAD:  return d;
      C_CLEAR: return '0;
      C_SCAN:  return {m[N-2:0], si};
      C_PRPG:  return {m[N-2:0], fb};
      C_SIGN:  return d ^ {m[N-2:0], fb};
      default: return m;
    endcase
  endfunction

  task automatic check_val(string tag, logic [N-1:0] got, logic [N-1:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, want);
    end
  endtask

  // Driver: present one cycle of stimulus and push its expected result
  task automatic step(logic r, logic en, logic [2:0] code, logic [N-1:0] d,
                      logic si, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; clk_en = en; sess_code = code; par_d = d; scan_in = si;
    mdl = model_next(mdl, r, en, code, d, si);
    e.q = mdl;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after every edge for which an item was pushed
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check_val(e.tag, q, e.q);
        checks++;
        if (scan_out !== e.q[N-1]) begin
          errors++;
          $display("FAIL R4 scan_out (%s): actual=%b expected=%b", e.tag, scan_out, e.q[N-1]);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog expired, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [2**N];
    int distinct;
    logic [N-1:0] seed;

    // R1: reset state
    step(1, 0, C_LOAD, 4'hF, 1, "R1 reset");
    step(1, 1, C_SCAN, 4'hF, 1, "R1 reset");

    // R3: parallel load
    step(0, 1, C_LOAD, 4'hA, 0, "R3 load A");
    step(0, 1, C_LOAD, 4'h5, 0, "R3 load 5");

    // R1: reset overrides a disabled enable and a load code
    step(1, 0, C_LOAD, 4'hE, 0, "R1 override");

    // R8: enable low holds under several codes
    step(0, 1, C_LOAD, 4'h9, 0, "R3 load 9");
    step(0, 0, C_LOAD, 4'hF, 1, "R8 hold load");
    step(0, 0, C_SCAN, 4'h0, 0, "R8 hold scan");
    step(0, 0, C_CLEAR, 4'h0, 0, "R8 hold clear");

    // R4: serial scan
    step(0, 1, C_SCAN, 4'h0, 1, "R4 scan");
    step(0, 1, C_SCAN, 4'hF, 0, "R4 scan");
    step(0, 1, C_SCAN, 4'h3, 1, "R4 scan");
    step(0, 1, C_SCAN, 4'h0, 1, "R4 scan");

    // R7: reserved codes hold
    step(0, 1, 3'b101, 4'h6, 0, "R7 reserved 101");
    step(0, 1, 3'b110, 4'h1, 1, "R7 reserved 110");
    step(0, 1, 3'b111, 4'hC, 0, "R7 reserved 111");

    // R2: clear
    step(0, 1, C_CLEAR, 4'hF, 1, "R2 clear");

    // R5: signature compaction
    step(0, 1, C_LOAD, 4'h3, 0, "R3 seed");
    step(0, 1, C_SIGN, 4'h8, 0, "R5 sign");
    step(0, 1, C_SIGN, 4'h1, 1, "R5 sign");
    step(0, 1, C_SIGN, 4'hF, 0, "R5 sign");
    step(0, 1, C_SIGN, 4'h0, 0, "R5 sign");
    step(0, 1, C_SIGN, 4'h6, 1, "R5 sign");

    // R6: pattern generation over a full period, data ignored
    seed = 4'h1;
    step(0, 1, C_LOAD, seed, 0, "R3 seed");
    foreach (seen[k]) seen[k] = 1'b0;
    for (int k = 0; k < (2**N) - 1; k++) begin
      step(0, 1, C_PRPG, N'($urandom), 1'($urandom), "R6 prpg");
      @(posedge clk);
      #2;
      seen[q] = 1'b1;
    end
    distinct = 0;
    for (int k = 1; k < 2**N; k++) if (seen[k]) distinct++;
    checks++;
    if (distinct != (2**N) - 1 || seen[0]) begin
      errors++;
      $display("FAIL R6 period: actual=%0d distinct nonzero (zero seen %0b) expected=%0d",
               distinct, seen[0], (2**N) - 1);
    end
    check_val("R6 returns to seed", q, seed);

    // R6: all-zero state is a fixed point
    step(0, 1, C_CLEAR, 4'h0, 0, "R2 clear");
    step(0, 1, C_PRPG, 4'hB, 1, "R6 zero fixed");
    step(0, 1, C_PRPG, 4'h7, 0, "R6 zero fixed");

    // R9: a different code on every edge
    step(0, 1, C_LOAD, 4'hC, 0, "R9 load");
    step(0, 1, C_SCAN, 4'h0, 1, "R9 scan");
    step(0, 1, C_SIGN, 4'h5, 0, "R9 sign");
    step(0, 1, C_PRPG, 4'hF, 0, "R9 prpg");
    step(0, 1, 3'b110, 4'h0, 1, "R9 reserved");
    step(0, 1, C_CLEAR, 4'h0, 0, "R9 clear");
    step(0, 1, C_LOAD, 4'h8, 0, "R9 load");
    step(0, 0, C_SIGN, 4'h3, 0, "R9 disabled sign");
    step(0, 1, C_SCAN, 4'h0, 0, "R9 scan");

    // drain
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule